// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block guards a three-phase brushless motor against a stalled rotor. It watches the three Hall sensor bits, derives one rotation pulse per full electrical Hall period, and runs a tick-driven timer that is cleared by every rotation pulse. A free-running prescaled tick from the system clock advances the timer. While the motor turns, the pulses keep the timer near its bottom, so protection stays idle.

If no rotation pulse arrives for `UP_TICKS` ticks, the block declares a locked rotor. It then cycles between two windows. The first is a long drive-off window of `DOWN_TICKS` ticks, during which the high-side outputs are inhibited. The second is a short drive-on window of `UP_TICKS` ticks, which lets the motor try to restart. The default lengths keep the off window about fifteen times longer than the on window.

The first rotation pulse ends protection immediately. Holding the enable input low turns the whole function off.

Top module: `rotor_lock_guard`

## Requirements
- R1: After reset, `hs_inhibit_o` is 0 and `spin_o` is 1, and the timer sits at the bottom of its ramp.
- R2: The Hall bits pass through a two-flop synchronizer. Every change of the XOR of the three synchronized bits counts as one Hall edge. Every `HALL_EDGES`-th edge (default 6) produces a rotation pulse, and that pulse returns the timer to its bottom in the running state.
- R3: While running and enabled, the cycle after the `UP_TICKS`-th tick with no rotation pulse, `spin_o` goes to 0 and `hs_inhibit_o` goes to 1. After `UP_TICKS`-1 such ticks, both outputs are unchanged.
- R4: Once locked, `hs_inhibit_o` stays 1 for exactly `DOWN_TICKS` ticks and then returns to 0.
- R5: In the locked drive-on window, `hs_inhibit_o` stays 0 for `UP_TICKS` ticks and then returns to 1. `spin_o` stays 0 throughout, and the off/on cycle repeats for as long as no pulse arrives.
- R6: A rotation pulse in either locked window returns the block to running on the next cycle, with `spin_o`=1 and `hs_inhibit_o`=0.
- R7: While `en_i` is 0, the block is forced to running with the timer at its bottom from the next cycle on, and `tick_i` has no effect on the outputs.
- R8: When a rotation pulse and a tick occur in the same cycle, the pulse wins and the timer restarts from its bottom.
- R9: Cycles with `tick_i` low and no rotation pulse leave both outputs unchanged.
- R10: `hs_inhibit_o` is never 1 while `spin_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Protection enable; 0 disables the function |
| hall_i | input | 3 | Raw Hall sensor bits, asynchronous |
| tick_i | input | 1 | One-cycle prescaled time base pulse |
| hs_inhibit_o | output | 1 | 1 blocks the high-side drive outputs |
| spin_o | output | 1 | 1 while rotation is considered normal, 0 when locked |

## Verification
The main pattern is a random mix of tick density, Hall steps along the six-step sequence, and short enable drops. It separates a correct edge divider from one that fires on every edge, and a correct window length from one that is off by one tick. Directed cases cover the lock threshold at `UP_TICKS`-1 against `UP_TICKS` ticks and a complete off/on cycle. They also release the lock with Hall motion and check a pulse coinciding with a tick. Each of these pins down one boundary that the random traffic rarely lands on exactly.

// File: rtl/rotor_lock_pkg.sv
package rotor_lock_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_OFF = 2'd1,
    ST_ON  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/hall_rev_pulse.sv
module hall_rev_pulse #(
  parameter int unsigned N_HALL     = 3,
  parameter int unsigned HALL_EDGES = 6,
  localparam int unsigned EW        = (HALL_EDGES > 1) ? $clog2(HALL_EDGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HALL-1:0] hall_i,
  output logic              pulse_o
);
  logic [N_HALL-1:0] sync1_q, sync2_q;
  logic              par_q, edge_w;
  logic [EW-1:0]     ecnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      par_q   <= 1'b0;
    end else begin
      sync1_q <= hall_i;
      sync2_q <= sync1_q;
      par_q   <= ^sync2_q;
    end
  end

  assign edge_w = (^sync2_q) != par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ecnt_q <= '0;
    else if (edge_w) begin
      if (ecnt_q == EW'(HALL_EDGES - 1)) ecnt_q <= '0;
      else                               ecnt_q <= ecnt_q + 1'b1;
    end
  end

  assign pulse_o = edge_w && (ecnt_q == EW'(HALL_EDGES - 1));
endmodule

// File: rtl/lock_ramp.sv
module lock_ramp
  import rotor_lock_pkg::*;
#(
  parameter int unsigned UP_TICKS   = 890,
  parameter int unsigned DOWN_TICKS = 13300,
  localparam int unsigned MAXT      = (UP_TICKS > DOWN_TICKS) ? UP_TICKS : DOWN_TICKS,
  localparam int unsigned CW        = $clog2(MAXT + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tick_i,
  input  logic        pulse_i,
  output lock_state_e state_o
);
  lock_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic last_up, last_down;

  assign last_up   = cnt_q == CW'(UP_TICKS - 1);
  assign last_down = cnt_q == CW'(DOWN_TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (!en_i || pulse_i) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_RUN, ST_ON: begin
          if (last_up) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_OFF: begin
          if (last_down) begin
            state_q <= ST_ON;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard
  import rotor_lock_pkg::*;
#(
  parameter int unsigned N_HALL     = 3,
  parameter int unsigned HALL_EDGES = 6,
  parameter int unsigned UP_TICKS   = 890,
  parameter int unsigned DOWN_TICKS = 13300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_HALL-1:0] hall_i,
  input  logic              tick_i,
  output logic              hs_inhibit_o,
  output logic              spin_o
);
  logic        rot_pulse;
  lock_state_e state;

  hall_rev_pulse #(.N_HALL(N_HALL), .HALL_EDGES(HALL_EDGES)) u_rev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hall_i (hall_i),
    .pulse_o(rot_pulse)
  );

  lock_ramp #(.UP_TICKS(UP_TICKS), .DOWN_TICKS(DOWN_TICKS)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_i),
    .pulse_i(rot_pulse),
    .state_o(state)
  );

  assign hs_inhibit_o = state == ST_OFF;
  assign spin_o       = state == ST_RUN;
endmodule

// File: rtl/rotor_lock_guard_chk.sv
module rotor_lock_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_i,
  input logic rot_pulse,
  input logic hs_inhibit_o,
  input logic spin_o
);
  AST_INHIBIT_ONLY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_inhibit_o |-> !spin_o); // R10
  AST_DISABLE_FORCES_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (spin_o && !hs_inhibit_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && !rot_pulse) |=> ($stable(spin_o) && $stable(hs_inhibit_o))); // R9
  AST_PULSE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_pulse |=> (spin_o && !hs_inhibit_o)); // R6
  AST_LOCK_STARTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spin_o) |-> hs_inhibit_o); // R3
  AST_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spin_o) |-> ($past(rot_pulse) || !$past(en_i))); // R6
endmodule

bind rotor_lock_guard rotor_lock_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .tick_i      (tick_i),
  .rot_pulse   (rot_pulse),
  .hs_inhibit_o(hs_inhibit_o),
  .spin_o      (spin_o)
);

// File: tb/rotor_lock_guard_tb.sv
module rotor_lock_guard_tb;
  localparam int unsigned UP = 4;
  localparam int unsigned DN = 60;
  localparam int unsigned HE = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, tick = 1'b0;
  logic [2:0] hall;
  logic inh, spin;
  int n_cmp = 0, n_bad = 0, cycles = 0, hidx = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0] m_s1 = '0, m_s2 = '0;
  logic m_par = 1'b0;
  int m_ecnt = 0, m_st = 0, m_cnt = 0; // 0 run, 1 off, 2 on

  always #10 clk = ~clk;

  rotor_lock_guard #(.HALL_EDGES(HE), .UP_TICKS(UP), .DOWN_TICKS(DN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hall_i(hall), .tick_i(tick),
    .hs_inhibit_o(inh), .spin_o(spin));

  function automatic logic [2:0] hall_code(int i);
    case (i % 6)
      0: return 3'b101; 1: return 3'b100; 2: return 3'b110;
      3: return 3'b010; 4: return 3'b011; default: return 3'b001;
    endcase
  endfunction

  function automatic logic exp_inh(int st); return st == 1; endfunction
  function automatic logic exp_spin(int st); return st == 0; endfunction

  task automatic model_step();
    logic edg, pul;
    edg = (^m_s2) != m_par;
    pul = edg && (m_ecnt == HE - 1);
    if (edg) m_ecnt = (m_ecnt == HE - 1) ? 0 : m_ecnt + 1;
    if (!en || pul) begin m_st = 0; m_cnt = 0; end
    else if (tick) begin
      if (m_st == 1) begin
        if (m_cnt == DN - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
      end else begin
        if (m_cnt == UP - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
      end
    end
    m_par = ^m_s2;
    m_s2  = m_s1;
    m_s1  = hall;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("model inh", inh, exp_inh(m_st));
      chk("model spin", spin, exp_spin(m_st));
    end
  endtask

  task automatic step_hall();
    hidx++;
    hall = hall_code(hidx);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    hall = hall_code(0);
    repeat (3) @(negedge clk);
    chk("R1 inh", inh, 1'b0);
    chk("R1 spin", spin, 1'b1);
    rst_n = 1'b1;
    cyc(4);
    // R3 threshold: UP-1 ticks not locked, UP-th locks
    tick = 1'b1; cyc(UP - 1); tick = 1'b0;
    chk("R3 below", spin, 1'b1);
    tick = 1'b1; cyc(1); tick = 1'b0;
    chk("R3 lock spin", spin, 1'b0);
    chk("R3 lock inh", inh, 1'b1);
    // R9 idle holds
    cyc(5);
    chk("R9 hold", inh, 1'b1);
    // R4 off window
    tick = 1'b1; cyc(DN - 1);
    chk("R4 still off", inh, 1'b1);
    cyc(1);
    chk("R4 off ends", inh, 1'b0);
    chk("R5 spin low", spin, 1'b0);
    // R5 on window
    cyc(UP - 1);
    chk("R5 on", inh, 1'b0);
    cyc(1);
    chk("R5 re-off", inh, 1'b1);
    tick = 1'b0;
    // R2/R6 release by rotation
    for (int i = 0; i < HE; i++) begin step_hall(); cyc(2); end
    cyc(3);
    chk("R6 released spin", spin, 1'b1);
    chk("R2 timer bottom", inh, 1'b0);
    // R7 disable ignores ticks
    en = 1'b0; tick = 1'b1; cyc(UP + DN + 5);
    chk("R7 spin", spin, 1'b1);
    chk("R7 inh", inh, 1'b0);
    en = 1'b1; tick = 1'b0; cyc(2);
    // R8 pulse with tick: steps with ticks every cycle near threshold
    tick = 1'b1; cyc(UP - 1);
    for (int i = 0; i < HE; i++) begin step_hall(); cyc(1); end
    cyc(2);
    chk("R8 model spin", spin, exp_spin(m_st));
    tick = 1'b0;
    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tick = (r < 40);
      if ($urandom_range(0, 99) < (i % 3000 < 1500 ? 8 : 1)) step_hall();
      en = !($urandom_range(0, 999) < 3) ? 1'b1 : 1'b0;
      cyc(1);
      chk("R10 exclusive", inh & spin, 1'b0);
    end
    done = 1'b1;
    finish_run();
  end
endmodule